// File: doc/BRIEF.md
# Screen RAM Write-Through Shadow Controller

This block sits between a CPU bus and two memories that share one address window. One is a slow video controller that owns display memory. The other is a fast static RAM laid over the same addresses. Each CPU write into the display window goes to both devices, so the picture stays current and the fast copy stays coherent. A CPU read in that window is answered by the fast RAM alone, so the video controller never drives the data bus on a read and its access penalty is paid only on writes. A second bank follows the display window directly. The video controller would normally serve it, but here it is handled entirely by the fast RAM.

The CPU side is a request/acknowledge pair. The address strobe is the request and must stay asserted, with address and direction stable, until the data acknowledge pulses. The strobe must then be released before a new access can begin. The slow side pushes back through its acknowledge level: while it stays low, a mirrored write is stalled and both write selects are held. Fast-RAM accesses are never stalled. Addresses outside both windows leave every output low, so another decoder can claim them.

Top module: `shadow_screen_wt`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `fram_sel`, `fram_we`, `vid_sel` and `cpu_dtack` are all low.
- R2: A write (`cpu_rnw`=0) to the display window (default 0x20000 to 0x27FFF) raises `fram_sel`, `fram_we` and `vid_sel` together in the cycle after the strobe is sampled high.
- R3: During a mirrored write, all three selects stay high for as long as `vid_ack` is sampled low, for any number of cycles.
- R4: In the cycle after `vid_ack` is sampled high during a mirrored write, the three selects drop together and `cpu_dtack` is high. The write latency is therefore two cycles plus the slow-side delay.
- R5: A read (`cpu_rnw`=1) in the display window raises `fram_sel` with `fram_we` low and `cpu_dtack` high in the cycle after the strobe is sampled. `vid_sel` stays low whatever `vid_ack` does.
- R6: Reads and writes in the spare bank (default 0x28000 to 0x37FFF) use only the fast RAM. They finish in one cycle with `fram_we` equal to the inverse of `cpu_rnw`, and `vid_sel` stays low.
- R7: While the strobe is held on an address outside both windows, no output is asserted.
- R8: `cpu_dtack` is high for exactly one cycle per access. A strobe still held after the acknowledge does not start a second access.
- R9: Window bounds are inclusive at the base and exclusive at the end. The last display address is mirrored, the first spare address is fast-only, and the addresses just below the display base and just past the spare end are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | ADDR_W (22) | CPU byte address |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| cpu_as | input | 1 | Address strobe / request, active high |
| vid_ack | input | 1 | Video controller completion level, active high |
| fram_sel | output | 1 | Fast RAM select |
| fram_we | output | 1 | Fast RAM write enable |
| vid_sel | output | 1 | Video controller select (writes only) |
| cpu_dtack | output | 1 | One-cycle data acknowledge to the CPU |

## Verification
The bench runs mirrored writes against slow-side delays from zero to fifteen cycles. A design that released the fast select early, or acknowledged before the video side finished, would show up as a wrong latency or a missing overlap of the selects. Display reads are also issued with the slow acknowledge already high. A design that let the video controller onto a read, or made read timing depend on it, would raise `vid_sel` or change the one-cycle latency. The bench also probes the addresses on either side of each window edge, and holds the strobe after an acknowledge to catch a design that decodes off by one or starts a second access.

// File: rtl/shadow_screen_pkg.sv
package shadow_screen_pkg;

  // Access sequencer states
  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,  // waiting for a strobe on a claimed address
    SQ_FAST  = 3'd1,  // single-cycle fast RAM access, acknowledged now
    SQ_WWAIT = 3'd2,  // mirrored write, waiting on the slow side
    SQ_ACK   = 3'd3,  // slow side finished, acknowledge the CPU
    SQ_DONE  = 3'd4   // wait for the strobe to be released
  } seq_state_t;

  // Decoded window of the current address
  typedef struct packed {
    logic disp;   // display window: mirrored writes
    logic spare;  // spare bank: fast RAM only
  } win_hit_t;

endpackage

// File: rtl/shadow_win_decode.sv
module shadow_win_decode
  import shadow_screen_pkg::*;
#(
  parameter int unsigned ADDR_W     = 22,
  parameter int unsigned DISP_BASE  = 32'h0002_0000,
  parameter int unsigned DISP_SIZE  = 32'h0000_8000,
  parameter int unsigned SPARE_SIZE = 32'h0001_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output win_hit_t          hit
);

  localparam int unsigned NWIN       = 2;
  localparam int unsigned SPARE_BASE = DISP_BASE + DISP_SIZE;

  logic [NWIN-1:0] in_win;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    localparam int unsigned W_BASE = (g == 0) ? DISP_BASE : SPARE_BASE;
    localparam int unsigned W_SIZE = (g == 0) ? DISP_SIZE : SPARE_SIZE;
    localparam bit POW2    = ((W_SIZE & (W_SIZE - 1)) == 0);
    localparam bit ALIGNED = POW2 && ((W_BASE % W_SIZE) == 0);

    if (ALIGNED) begin : g_mask
      // aligned power-of-two window: compare upper bits only
      localparam logic [ADDR_W-1:0] MASK = ~(ADDR_W'(W_SIZE - 1));
      localparam logic [ADDR_W-1:0] BASE = ADDR_W'(W_BASE);
      assign in_win[g] = ((addr & MASK) == BASE);
    end else begin : g_range
      // arbitrary window: two magnitude comparisons
      localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(W_BASE);
      localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(W_BASE + W_SIZE);
      logic [ADDR_W:0] a_ext;
      assign a_ext     = {1'b0, addr};
      assign in_win[g] = (a_ext >= LO) && (a_ext < HI);
    end
  end

  assign hit.disp  = in_win[0];
  assign hit.spare = in_win[1];

endmodule

// File: rtl/shadow_access_seq.sv
module shadow_access_seq
  import shadow_screen_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req,
  input  logic     rnw,
  input  win_hit_t hit,
  input  logic     slow_ack,
  output logic     fast_sel,
  output logic     fast_we,
  output logic     slow_sel,
  output logic     done
);

  seq_state_t st_q, st_d;
  logic       rnw_q;
  logic       claim;
  logic       mirror;

  assign claim  = req && (hit.disp || hit.spare);
  assign mirror = hit.disp && !rnw;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE:  if (claim) st_d = mirror ? SQ_WWAIT : SQ_FAST;
      SQ_FAST:  st_d = SQ_DONE;
      SQ_WWAIT: if (slow_ack) st_d = SQ_ACK;
      SQ_ACK:   st_d = SQ_DONE;
      SQ_DONE:  if (!req) st_d = SQ_IDLE;
      default:  st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      rnw_q <= 1'b1;
    end else begin
      st_q <= st_d;
      if (st_q == SQ_IDLE && claim) rnw_q <= rnw;
    end
  end

  assign fast_sel = (st_q == SQ_FAST) || (st_q == SQ_WWAIT);
  assign fast_we  = ((st_q == SQ_FAST) && !rnw_q) || (st_q == SQ_WWAIT);
  assign slow_sel = (st_q == SQ_WWAIT);
  assign done     = (st_q == SQ_FAST) || (st_q == SQ_ACK);

endmodule

// File: rtl/shadow_screen_wt.sv
module shadow_screen_wt
  import shadow_screen_pkg::*;
#(
  parameter int unsigned ADDR_W     = 22,
  parameter int unsigned DISP_BASE  = 32'h0002_0000,
  parameter int unsigned DISP_SIZE  = 32'h0000_8000,
  parameter int unsigned SPARE_SIZE = 32'h0001_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rnw,
  input  logic              cpu_as,
  input  logic              vid_ack,
  output logic              fram_sel,
  output logic              fram_we,
  output logic              vid_sel,
  output logic              cpu_dtack
);

  win_hit_t hit;

  shadow_win_decode #(
    .ADDR_W    (ADDR_W),
    .DISP_BASE (DISP_BASE),
    .DISP_SIZE (DISP_SIZE),
    .SPARE_SIZE(SPARE_SIZE)
  ) u_decode (
    .addr(cpu_addr),
    .hit (hit)
  );

  shadow_access_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (cpu_as),
    .rnw     (cpu_rnw),
    .hit     (hit),
    .slow_ack(vid_ack),
    .fast_sel(fram_sel),
    .fast_we (fram_we),
    .slow_sel(vid_sel),
    .done    (cpu_dtack)
  );

endmodule

// File: rtl/shadow_screen_wt_chk.sv
module shadow_screen_wt_chk (
  input logic clk,
  input logic rst_n,
  input logic cpu_as,
  input logic vid_ack,
  input logic fram_sel,
  input logic fram_we,
  input logic vid_sel,
  input logic cpu_dtack
);

  // R2
  mirror_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vid_sel |-> (fram_sel && fram_we));

  // R3
  hold_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_sel && !vid_ack) |=> (vid_sel && fram_sel && fram_we));

  // R4
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_sel && vid_ack) |=> (cpu_dtack && !vid_sel && !fram_sel));

  // R5
  fast_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fram_sel && !fram_we) |-> (cpu_dtack && !vid_sel));

  // R8
  single_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_dtack |=> !cpu_dtack);

  // R8
  strobe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fram_sel) |-> $past(cpu_as));

endmodule

bind shadow_screen_wt shadow_screen_wt_chk u_chk (.*);

// File: tb/test_shadow_screen_wt.sv
module test_shadow_screen_wt;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [21:0] cpu_addr = '0;
  logic        cpu_rnw = 1'b1;
  logic        cpu_as = 1'b0;
  logic        vid_ack = 1'b0;
  logic        fram_sel, fram_we, vid_sel, cpu_dtack;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  shadow_screen_wt i_shadow_screen_wt (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .cpu_rnw  (cpu_rnw),
    .cpu_as   (cpu_as),
    .vid_ack  (vid_ack),
    .fram_sel (fram_sel),
    .fram_we  (fram_we),
    .vid_sel  (vid_sel),
    .cpu_dtack(cpu_dtack)
  );

  // {kind[1:0], slow delay[4:0], rnw, addr[21:0]}; kind 0 none, 1 fast, 2 mirror
  localparam int NVEC = 12;
  localparam logic [29:0] VEC [NVEC] = '{
    {2'd2, 5'd0,  1'b0, 22'h020000},  // R2 R4 display base (R9)
    {2'd2, 5'd3,  1'b0, 22'h021234},  // R2 R3 R4
    {2'd2, 5'd7,  1'b0, 22'h027FFF},  // R9 last display address
    {2'd1, 5'd5,  1'b1, 22'h020010},  // R5 display read
    {2'd1, 5'd0,  1'b1, 22'h027FFF},  // R5 R9
    {2'd1, 5'd4,  1'b0, 22'h028000},  // R6 R9 first spare address
    {2'd1, 5'd0,  1'b1, 22'h030000},  // R6 read
    {2'd1, 5'd2,  1'b0, 22'h037FFF},  // R6 last spare address
    {2'd0, 5'd0,  1'b0, 22'h01FFFF},  // R7 R9 below display
    {2'd0, 5'd0,  1'b1, 22'h038000},  // R7 R9 past spare
    {2'd2, 5'd15, 1'b0, 22'h024000},  // R3 long stall
    {2'd0, 5'd0,  1'b1, 22'h000000}   // R7
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_access(input logic [21:0] a, input logic rnw, input int dly,
                            input int kind, input string req);
    int  cyc = 0;
    int  vcyc = 0;
    bit  got = 1'b0;
    @(negedge clk);
    cpu_addr = a; cpu_rnw = rnw; cpu_as = 1'b1;
    if (kind == 0) begin
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        check(!(fram_sel || fram_we || vid_sel || cpu_dtack), req,
              {28'd0, fram_sel, fram_we, vid_sel, cpu_dtack}, 32'd0);
      end
      cpu_as = 1'b0;
      repeat (2) @(negedge clk);
      return;
    end
    while (!got && cyc < 64) begin
      @(negedge clk);
      cyc++;
      if (cpu_dtack) got = 1'b1;
      else if (vid_sel) begin
        check(fram_sel && fram_we, "R3 selects held", {30'd0, fram_sel, fram_we}, 32'd3);
        if (vcyc >= dly) vid_ack = 1'b1;
        vcyc++;
      end
    end
    if (kind == 1) begin
      check(cyc == 1, {req, " latency"}, cyc, 1);
      check(fram_sel && (fram_we == !rnw) && !vid_sel, {req, " selects"},
            {29'd0, fram_sel, fram_we, vid_sel}, {29'd0, 1'b1, !rnw, 1'b0});
    end else begin
      check(cyc == dly + 2, "R4 write latency", cyc, dly + 2);
      check(vcyc == dly + 1, "R2 R3 video select cycles", vcyc, dly + 1);
      check(!fram_sel && !vid_sel, "R4 release together", {30'd0, fram_sel, vid_sel}, 32'd0);
    end
    cpu_as = 1'b0;
    vid_ack = 1'b0;
    @(negedge clk);
    check(!cpu_dtack, "R8 single acknowledge", cpu_dtack, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state, strobe already on a claimed address
    cpu_addr = 22'h020000; cpu_rnw = 1'b0; cpu_as = 1'b1;
    repeat (3) @(negedge clk);
    check(!(fram_sel || fram_we || vid_sel || cpu_dtack), "R1 in reset",
          {28'd0, fram_sel, fram_we, vid_sel, cpu_dtack}, 32'd0);
    cpu_as = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check(!(fram_sel || fram_we || vid_sel || cpu_dtack), "R1 after reset",
          {28'd0, fram_sel, fram_we, vid_sel, cpu_dtack}, 32'd0);

    for (int v = 0; v < NVEC; v++) begin
      logic [29:0] e;
      string       rq;
      e = VEC[v];
      if (e[29:28] == 2'd0) rq = "R7 outside";
      else if (e[29:28] == 2'd2) rq = "R2 mirrored write";
      else if (e[21:0] >= 22'h028000) rq = "R6 spare bank";
      else rq = "R5 display read";
      run_access(e[21:0], e[22], int'(e[27:23]), int'(e[29:28]), rq);
    end

    // R5 read while slow side already acknowledges
    vid_ack = 1'b1;
    run_access(22'h022222, 1'b1, 0, 1, "R5 read ignores vid_ack");

    // R8 strobe held after acknowledge
    @(negedge clk);
    cpu_addr = 22'h020100; cpu_rnw = 1'b1; cpu_as = 1'b1;
    @(negedge clk);
    check(cpu_dtack, "R8 first acknowledge", cpu_dtack, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!cpu_dtack && !fram_sel, "R8 held strobe no restart",
            {30'd0, cpu_dtack, fram_sel}, 32'd0);
    end
    cpu_as = 1'b0;
    repeat (2) @(negedge clk);

    // R2 back-to-back mirrored write after release
    run_access(22'h026000, 1'b0, 1, 2, "R2 mirrored write");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule